// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Three-Bit Instruction Decoder

This block is the test access port of a chip: a sixteen-state controller clocked by the test clock, a three-bit instruction register with separate shift and hold stages, a decoder, a single-bit bypass register, a 32-bit identification register and the multiplexer that feeds the serial test output. Its serial input and the mode, clock and reset pins are the only stimulus. A tester walks the controller through instruction and data scans to pick a data path and a pin mode.

The boundary-scan cells and the pads lie outside the block. The serial input of the boundary chain is wired directly to the test data input. The chain's serial output comes back on `bsr_so`. The block tells the chain when it is selected and when to capture, shift and update. It also tells the pad ring whether to drive the pins from the chain's held values or to float them. The instruction register's hold stage loads on the falling test-clock edge in the Update-IR state. The test output also changes on falling edges.

Top module: `tap_port`

## Requirements
- R1: In Test-Logic-Reset, reached either by holding `trst_n` low or by five rising edges with TMS high, the held instruction becomes IDCODE (001). `bsr_drive`, `bsr_hiz` and `bsr_sel` are then all low.
- R2: In Capture-IR the instruction shift stage loads 001. During Shift-IR it shifts toward TDO least significant bit first, so the first three bits read out are 1, 0, 0.
- R3: The held instruction, and so every decoded mode output, changes only on the falling edge while the controller is in Update-IR. Shifting a new opcode in, and the rising edge that enters Update-IR, leave the outputs unchanged.
- R4: The opcodes are 000 EXTEST, 001 IDCODE, 010 SAMPLE/PRELOAD, 011 CLAMP, 100 HIGHZ and 111 BYPASS. The unused codes 101 and 110 act exactly as BYPASS.
- R5: With BYPASS, CLAMP or HIGHZ held, the serial path is one bit long. It captures 0 in Capture-DR, then echoes TDI delayed by one shift.
- R6: With IDCODE held, Capture-DR loads a 32-bit constant whose least significant bit is 1. Shift-DR reads it out least significant bit first.
- R7: With EXTEST or SAMPLE/PRELOAD held, `bsr_sel` is high and TDO during Shift-DR carries `bsr_so`.
- R8: `bsr_capture`, `bsr_shift` and `bsr_update` are high only in Capture-DR, Shift-DR and Update-DR respectively, and only while the boundary chain is selected. At most one of them is high at a time.
- R9: `bsr_drive` is high under EXTEST and CLAMP. `bsr_hiz` is high under HIGHZ only. Both are low under SAMPLE/PRELOAD, IDCODE and BYPASS.
- R10: TDO and `tdo_en` change on the falling edge of TCK. `tdo_en` is high only while the controller is in Shift-IR or Shift-DR, and TDO is 0 whenever `tdo_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, sampled on TCK edges |
| tms | input | 1 | Test mode select, steers the controller |
| tdi | input | 1 | Serial test data in; also feeds the boundary chain |
| bsr_so | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial test data out, updated on falling TCK |
| tdo_en | output | 1 | Output enable for TDO |
| bsr_sel | output | 1 | Boundary chain is the selected data path |
| bsr_capture | output | 1 | Boundary chain capture strobe |
| bsr_shift | output | 1 | Boundary chain shift strobe |
| bsr_update | output | 1 | Boundary chain update strobe |
| bsr_drive | output | 1 | Pins driven from the chain's held values |
| bsr_hiz | output | 1 | Pins forced to high impedance |

## Verification
The assertions assume `trst_n` is held low for at least two rising TCK edges before release. The reset state must be established before any property looks at past values. They also assume TMS and TDI change only away from TCK edges. The bench meets both. It asserts reset for three clocks at the start, and it changes every input just after a falling edge, half a period clear of the rising edge that samples it. Opcodes reach the block only through complete instruction scans that pass through Update-IR.

// File: rtl/tap_port_pkg.sv
package tap_port_pkg;

    localparam int IR_W = 3;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        SEL_BYPASS, SEL_IDENT, SEL_CHAIN
    } dr_sel_e;

    typedef struct packed {
        dr_sel_e path;
        logic    drive;
        logic    hiz;
    } ir_ctl_t;

    localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b010;
    localparam logic [IR_W-1:0] OP_CLAMP   = 3'b011;
    localparam logic [IR_W-1:0] OP_HIGHZ   = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    function automatic tap_state_e tap_next(tap_state_e s, logic tms);
        tap_state_e n;
        case (s)
            ST_RESET:  n = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   n = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: n = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = tms ? ST_SEL_DR : ST_IDLE;
            default:   n = ST_RESET;
        endcase
        return n;
    endfunction

    function automatic ir_ctl_t ir_decode(logic [IR_W-1:0] op);
        ir_ctl_t c;
        c = '{path: SEL_BYPASS, drive: 1'b0, hiz: 1'b0};
        case (op)
            OP_EXTEST: begin c.path = SEL_CHAIN; c.drive = 1'b1; end
            OP_IDCODE: c.path = SEL_IDENT;
            OP_SAMPLE: c.path = SEL_CHAIN;
            OP_CLAMP:  c.drive = 1'b1;
            OP_HIGHZ:  c.hiz = 1'b1;
            default:   c.path = SEL_BYPASS;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tap_ctrl.sv
module tap_ctrl
    import tap_port_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge tck) begin
        if (rst) state <= ST_RESET;
        else     state <= tap_next(state, tms);
    end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_port_pkg::*;
(
    input  logic            tck,
    input  logic            rst,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_q,
    output logic            sh_lsb
);

    logic [IR_W-1:0] ir_sh;

    // shift stage works on rising edges
    always_ff @(posedge tck) begin
        if (rst)                   ir_sh <= IR_CAPTURE;
        else if (state == ST_CAP_IR) ir_sh <= IR_CAPTURE;
        else if (state == ST_SH_IR)  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end

    // hold stage loads on the falling edge
    always_ff @(negedge tck) begin
        if (rst || state == ST_RESET) ir_q <= OP_IDCODE;
        else if (state == ST_UPD_IR)  ir_q <= ir_sh;
    end

    assign sh_lsb = ir_sh[0];

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_port_pkg::*;
#(
    parameter int              ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h4A6B_C0D3
) (
    input  logic       tck,
    input  logic       rst,
    input  tap_state_e state,
    input  dr_sel_e    path,
    input  logic       tdi,
    output logic       byp_q,
    output logic       id_lsb
);

    logic [ID_W-1:0] id_sh;

    always_ff @(posedge tck) begin
        if (rst)                    byp_q <= 1'b0;
        else if (path == SEL_BYPASS) begin
            if (state == ST_CAP_DR)     byp_q <= 1'b0;
            else if (state == ST_SH_DR) byp_q <= tdi;
        end
    end

    generate
        if (ID_W > 1) begin : g_id_wide
            always_ff @(posedge tck) begin
                if (rst)                   id_sh <= ID_VALUE;
                else if (path == SEL_IDENT) begin
                    if (state == ST_CAP_DR)     id_sh <= ID_VALUE;
                    else if (state == ST_SH_DR) id_sh <= {tdi, id_sh[ID_W-1:1]};
                end
            end
        end else begin : g_id_bit
            always_ff @(posedge tck) begin
                if (rst)                   id_sh <= ID_VALUE;
                else if (path == SEL_IDENT) begin
                    if (state == ST_CAP_DR)     id_sh <= ID_VALUE;
                    else if (state == ST_SH_DR) id_sh <= tdi;
                end
            end
        end
    endgenerate

    assign id_lsb = id_sh[0];

endmodule

// File: rtl/tap_port.sv
module tap_port
    import tap_port_pkg::*;
#(
    parameter int              ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h4A6B_C0D3
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    input  logic bsr_so,
    output logic tdo,
    output logic tdo_en,
    output logic bsr_sel,
    output logic bsr_capture,
    output logic bsr_shift,
    output logic bsr_update,
    output logic bsr_drive,
    output logic bsr_hiz
);

    logic            rst;
    tap_state_e      state;
    logic [IR_W-1:0] ir_q;
    logic            ir_lsb;
    ir_ctl_t         ctl;
    logic            byp_q;
    logic            id_lsb;
    logic            dr_bit;

    assign rst = ~trst_n;

    tap_ctrl u_ctrl (
        .tck   (tck),
        .rst   (rst),
        .tms   (tms),
        .state (state)
    );

    tap_ir u_ir (
        .tck    (tck),
        .rst    (rst),
        .state  (state),
        .tdi    (tdi),
        .ir_q   (ir_q),
        .sh_lsb (ir_lsb)
    );

    always_comb ctl = ir_decode(ir_q);

    tap_dr #(
        .ID_W     (ID_W),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck    (tck),
        .rst    (rst),
        .state  (state),
        .path   (ctl.path),
        .tdi    (tdi),
        .byp_q  (byp_q),
        .id_lsb (id_lsb)
    );

    always_comb begin
        case (ctl.path)
            SEL_IDENT: dr_bit = id_lsb;
            SEL_CHAIN: dr_bit = bsr_so;
            default:   dr_bit = byp_q;
        endcase
    end

    // serial output retimed to the falling edge
    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            case (state)
                ST_SH_IR: begin tdo <= ir_lsb; tdo_en <= 1'b1; end
                ST_SH_DR: begin tdo <= dr_bit; tdo_en <= 1'b1; end
                default:  begin tdo <= 1'b0;   tdo_en <= 1'b0; end
            endcase
        end
    end

    assign bsr_sel     = (ctl.path == SEL_CHAIN);
    assign bsr_capture = bsr_sel && (state == ST_CAP_DR);
    assign bsr_shift   = bsr_sel && (state == ST_SH_DR);
    assign bsr_update  = bsr_sel && (state == ST_UPD_DR);
    assign bsr_drive   = ctl.drive;
    assign bsr_hiz     = ctl.hiz;

endmodule

// File: rtl/tap_port_chk.sv
module tap_port_chk
    import tap_port_pkg::*;
(
    input logic            tck,
    input logic            trst_n,
    input tap_state_e      state,
    input logic [IR_W-1:0] ir_q,
    input logic            tdo,
    input logic            tdo_en,
    input logic            bsr_sel,
    input logic            bsr_capture,
    input logic            bsr_shift,
    input logic            bsr_update,
    input logic            bsr_drive,
    input logic            bsr_hiz
);

    // R1: a settled reset state holds IDCODE with modes released
    p_reset_idcode_r1: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_RESET && $past(state) == ST_RESET) |->
            (ir_q == OP_IDCODE && !bsr_drive && !bsr_hiz && !bsr_sel));

    // R3: held instruction only moves across an Update-IR or reset falling edge
    p_ir_hold_r3: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_UPD_IR && state != ST_RESET) |-> (ir_q == $past(ir_q)));

    // R4: unused opcodes behave as bypass
    p_spare_bypass_r4: assert property (@(posedge tck) disable iff (!trst_n)
        (ir_q == 3'b101 || ir_q == 3'b110) |-> (!bsr_sel && !bsr_drive && !bsr_hiz));

    // R8: strobes mutually exclusive and only with the chain selected
    p_strobe_onehot_r8: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({bsr_capture, bsr_shift, bsr_update}));

    p_strobe_sel_r8: assert property (@(posedge tck) disable iff (!trst_n)
        (bsr_capture || bsr_shift || bsr_update) |-> bsr_sel);

    // R9: never drive and float at once
    p_drive_hiz_r9: assert property (@(posedge tck) disable iff (!trst_n)
        !(bsr_drive && bsr_hiz));

    // R10: output enable tracks the shift states, data low when disabled
    p_tdo_en_r10: assert property (@(posedge tck) disable iff (!trst_n)
        $past(trst_n) |-> (tdo_en == (state == ST_SH_IR || state == ST_SH_DR)));

    p_tdo_quiet_r10: assert property (@(posedge tck) disable iff (!trst_n)
        !tdo_en |-> !tdo);

endmodule

bind tap_port tap_port_chk i_chk (
    .tck         (tck),
    .trst_n      (trst_n),
    .state       (state),
    .ir_q        (ir_q),
    .tdo         (tdo),
    .tdo_en      (tdo_en),
    .bsr_sel     (bsr_sel),
    .bsr_capture (bsr_capture),
    .bsr_shift   (bsr_shift),
    .bsr_update  (bsr_update),
    .bsr_drive   (bsr_drive),
    .bsr_hiz     (bsr_hiz)
);

// File: tb/test_tap_port.sv
module test_tap_port;

    localparam int          CLK_P  = 10;
    localparam logic [31:0] ID_VAL = 32'h4A6B_C0D3;
    localparam int          WDOG   = 20000;

    // {opcode[2:0], path[1:0] (0 bypass,1 ident,2 chain), drive, hiz}
    localparam logic [6:0] VEC [0:7] = '{
        {3'b000, 2'd2, 1'b1, 1'b0},
        {3'b001, 2'd1, 1'b0, 1'b0},
        {3'b010, 2'd2, 1'b0, 1'b0},
        {3'b011, 2'd0, 1'b1, 1'b0},
        {3'b100, 2'd0, 1'b0, 1'b1},
        {3'b101, 2'd0, 1'b0, 1'b0},
        {3'b110, 2'd0, 1'b0, 1'b0},
        {3'b111, 2'd0, 1'b0, 1'b0}
    };

    logic tck = 1'b0;
    logic trst_n, tms, tdi, bsr_so;
    logic tdo, tdo_en, bsr_sel, bsr_capture, bsr_shift, bsr_update, bsr_drive, bsr_hiz;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 0;

    tap_port i_tap_port (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bsr_so(bsr_so),
        .tdo(tdo), .tdo_en(tdo_en), .bsr_sel(bsr_sel), .bsr_capture(bsr_capture),
        .bsr_shift(bsr_shift), .bsr_update(bsr_update), .bsr_drive(bsr_drive),
        .bsr_hiz(bsr_hiz)
    );

    always #(CLK_P/2) tck = ~tck;

    always @(posedge tck) begin
        cycles <= cycles + 1;
        if (cycles > WDOG && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // apply inputs, take one rising edge, return just after the falling edge
    task automatic clk_in(input logic m, input logic d);
        tms = m; tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    task automatic ir_scan(input logic [2:0] op, output logic [2:0] cap);
        logic [2:0] pre;
        clk_in(1, 0); clk_in(1, 0); clk_in(0, 0); clk_in(0, 0);
        pre = {bsr_sel, bsr_drive, bsr_hiz};
        for (int i = 0; i < 3; i++) begin
            cap[i] = tdo;
            clk_in(i == 2, op[i]);
        end
        chk({bsr_sel, bsr_drive, bsr_hiz} == pre, "R3 modes held after shift", {bsr_sel, bsr_drive, bsr_hiz}, pre);
        tms = 1;
        @(posedge tck); #1;
        chk({bsr_sel, bsr_drive, bsr_hiz} == pre, "R3 modes held at update rise", {bsr_sel, bsr_drive, bsr_hiz}, pre);
        @(negedge tck); #1;
        clk_in(0, 0);
    endtask

    task automatic dr_scan(input logic [1:0] path);
        int          n;
        logic [3:0]  pat;
        logic        exp;
        pat = 4'b1101;
        n = (path == 2'd1) ? 32 : 4;
        clk_in(1, 0);
        clk_in(0, 0);
        chk(bsr_capture == (path == 2'd2), "R8 capture strobe", bsr_capture, (path == 2'd2));
        clk_in(0, 0);
        chk(tdo_en == 1'b1, "R10 enable in shift", tdo_en, 1);
        chk(bsr_shift == (path == 2'd2), "R8 shift strobe", bsr_shift, (path == 2'd2));
        for (int i = 0; i < n; i++) begin
            case (path)
                2'd1:    exp = ID_VAL[i];
                2'd2:    exp = 1'b1;
                default: exp = (i == 0) ? 1'b0 : pat[i-1];
            endcase
            case (path)
                2'd1:    chk(tdo == exp, "R6 ident bit", tdo, exp);
                2'd2:    chk(tdo == exp, "R7 chain bit", tdo, exp);
                default: chk(tdo == exp, "R5 bypass bit", tdo, exp);
            endcase
            clk_in(i == n - 1, (path == 2'd0) ? pat[i] : 1'b0);
        end
        clk_in(1, 0);
        chk(bsr_update == (path == 2'd2), "R8 update strobe", bsr_update, (path == 2'd2));
        clk_in(0, 0);
        chk(tdo_en == 1'b0 && tdo == 1'b0, "R10 quiet outside shift", {tdo_en, tdo}, 0);
    endtask

    initial begin
        logic [2:0] cap;
        trst_n = 0; tms = 1; tdi = 0; bsr_so = 1;
        repeat (3) clk_in(1, 0);
        chk({bsr_sel, bsr_drive, bsr_hiz} == 3'b000, "R1 modes after trst", {bsr_sel, bsr_drive, bsr_hiz}, 0);
        chk(tdo_en == 1'b0, "R10 enable low in reset", tdo_en, 0);
        trst_n = 1;
        clk_in(0, 0);
        dr_scan(2'd1);   // R1: IDCODE selected after reset

        // table walk over every opcode
        for (int v = 0; v < 8; v++) begin
            ir_scan(VEC[v][6:4], cap);
            chk(cap == 3'b001, "R2 capture pattern", cap, 3'b001);
            chk(bsr_sel == (VEC[v][3:2] == 2'd2), "R4 path select", bsr_sel, (VEC[v][3:2] == 2'd2));
            chk(bsr_drive == VEC[v][1], "R9 drive mode", bsr_drive, VEC[v][1]);
            chk(bsr_hiz == VEC[v][0], "R9 hiz mode", bsr_hiz, VEC[v][0]);
            dr_scan(VEC[v][3:2]);
        end

        // R10: TDO moves on the falling edge only
        ir_scan(3'b111, cap);
        clk_in(1, 0); clk_in(0, 0); clk_in(0, 0);
        chk(tdo == 1'b0, "R10 captured bypass bit", tdo, 0);
        tms = 0; tdi = 1;
        @(posedge tck); #1;
        chk(tdo == 1'b0, "R10 tdo steady after rise", tdo, 0);
        @(negedge tck); #1;
        chk(tdo == 1'b1, "R10 tdo after fall", tdo, 1);
        clk_in(1, 0); clk_in(1, 0); clk_in(0, 0);

        // R1: five TMS-high clocks release EXTEST
        ir_scan(3'b000, cap);
        chk(bsr_drive == 1'b1, "R9 extest drives", bsr_drive, 1);
        repeat (5) clk_in(1, 0);
        chk({bsr_sel, bsr_drive, bsr_hiz} == 3'b000, "R1 modes after tms reset", {bsr_sel, bsr_drive, bsr_hiz}, 0);
        clk_in(0, 0);
        dr_scan(2'd1);

        // R1: trst in the middle of HIGHZ
        ir_scan(3'b100, cap);
        chk(bsr_hiz == 1'b1, "R9 highz floats", bsr_hiz, 1);
        trst_n = 0;
        clk_in(0, 0); clk_in(0, 0);
        trst_n = 1;
        chk({bsr_sel, bsr_drive, bsr_hiz} == 3'b000, "R1 trst releases highz", {bsr_sel, bsr_drive, bsr_hiz}, 0);
        clk_in(0, 0);
        dr_scan(2'd1);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule